// File: doc/BRIEF.md
# Configuration-Window Indirect Register Bridge

This block sits inside a device's configuration space. It lets a host reach the device's memory-mapped register region through three configuration words, without the region ever being mapped into the host address space. The host first programs a region selector, a length and a byte offset. It then touches a 32-bit data window. A window write stores the written bytes and pushes the window out to the register region. A window read pulls data from the register region into the window first, then hands the window back.

The width of each register-region access is set by the programmed length field, never by the byte enables of the configuration access that triggers it. Before any window access starts, the bridge checks the programmed fields against the size of the single register region. It answers an illegal combination with an error response and starts no bus traffic. The device side is a simple register-bus master: a one-cycle request with address, write data and a bit mask, completed by a response strobe carrying read data.

Top module: `cfgwin_bridge`

## Requirements
- R1: Configuration word 0 holds the region selector in bits [7:0] and the length in bits [15:8], with bits [31:16] reading zero. Word 1 holds the 32-bit offset. Writes to words 0 and 1 update only the byte lanes whose enable is set, start no bus access and never report an error. Reads of these words return the stored value ANDed with the byte-enable lanes.
- R2: A valid write to word 2 (the window) merges the enabled bytes into the window. It then issues exactly one bus write at the stored offset, with bus_wdata equal to the merged window.
- R3: The bus mask is 0x000000FF for length 1, 0x0000FFFF for length 2 and 0xFFFFFFFF for length 4, whatever byte enables the configuration access carried.
- R4: A valid read of the window issues exactly one bus read at the stored offset. The window is loaded with bus_rdata ANDed with the bus mask, so bytes above the length become zero. cfg_rdata then returns the window ANDed with the host's byte-enable lanes.
- R5: An access is valid only if the selector is 0, the length is 1, 2 or 4, the offset is a whole multiple of the length, offset < BAR_BYTES and offset + length ≤ BAR_BYTES.
- R6: An invalid window write completes with cfg_err set, issues no bus access and leaves the window unchanged.
- R7: An invalid window read completes with cfg_err set and issues no bus access. It returns the current window contents under the host's byte enables.
- R8: A request is accepted on a clock edge where cfg_req and cfg_ready are both high. cfg_ready stays low from acceptance of a valid window access until its completion. bus_req is high for exactly one cycle per access. cfg_ack pulses in the cycle after the edge that samples bus_resp. cfg_err is only ever high together with cfg_ack.
- R9: After reset, cfg_ready is 1, cfg_ack, cfg_err and bus_req are 0, and every field and the window read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Host request, held until accepted |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 2 | Word select: 0 control, 1 offset, 2 window |
| cfg_be | input | 4 | Host byte enables |
| cfg_wdata | input | 32 | Host write data |
| cfg_ready | output | 1 | Bridge can accept a request |
| cfg_ack | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Error flag, valid with cfg_ack |
| cfg_rdata | output | 32 | Host read data, valid with cfg_ack |
| bus_req | output | 1 | One-cycle register-bus request |
| bus_we | output | 1 | Register-bus write |
| bus_addr | output | BAR_AW | Byte offset into the register region |
| bus_wdata | output | 32 | Register-bus write data |
| bus_mask | output | 32 | Bit mask derived from the length |
| bus_resp | input | 1 | Register-bus completion strobe |
| bus_rdata | input | 32 | Register-bus read data, valid with bus_resp |

## Verification
The hardest situation to reach is a window access whose host byte enables disagree with the programmed length. In that case the mask on the bus and the bytes returned to the host come from two different sources, and the upper read lanes must come back zero even though the bus returns live data there. The stimulus gets there by programming the length and offset through the field words, then touching the window with narrower or wider enables than the length. The bench bus model returns nonzero bytes above the length, so a missing zeroing step is visible. Illegal field combinations are reached the same way: the fields are written one at a time, and the window is touched while the combination is bad.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_OFFS = 2'd1;
  localparam logic [1:0] A_WIN  = 2'd2;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_st_t;

  // expand 4 byte enables into a 32-bit bit mask
  function automatic logic [31:0] lanes_to_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  // bus bit mask selected by the programmed length
  function automatic logic [31:0] len_to_bits(input logic [7:0] len);
    case (len)
      8'd1:    return 32'h0000_00FF;
      8'd2:    return 32'h0000_FFFF;
      8'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/cfgwin_fields.sv
module cfgwin_fields
  import cfgwin_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fld_we,
  input  logic [1:0]    fld_addr,
  input  logic [DW/8-1:0] fld_be,
  input  logic [DW-1:0] fld_wdata,
  input  logic          win_ld,
  input  logic [DW-1:0] win_d,
  output logic [7:0]    bar_sel,
  output logic [7:0]    len,
  output logic [DW-1:0] offs,
  output logic [DW-1:0] window
);
  localparam int unsigned NB = DW / 8;

  // offset: one register per byte lane
  for (genvar b = 0; b < NB; b++) begin : g_offs
    always_ff @(posedge clk) begin
      if (rst) offs[8*b +: 8] <= '0;
      else if (fld_we && fld_addr == A_OFFS && fld_be[b])
        offs[8*b +: 8] <= fld_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_sel <= '0;
      len     <= '0;
    end else if (fld_we && fld_addr == A_CTRL) begin
      if (fld_be[0]) bar_sel <= fld_wdata[7:0];
      if (fld_be[1]) len     <= fld_wdata[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         window <= '0;
    else if (win_ld) window <= win_d;
  end
endmodule

// File: rtl/cfgwin_validate.sv
module cfgwin_validate
  import cfgwin_pkg::*;
#(
  parameter int unsigned BAR_BYTES = 256
) (
  input  logic [7:0]  bar_sel,
  input  logic [7:0]  len,
  input  logic [31:0] offs,
  output logic        acc_ok,
  output logic [31:0] acc_mask
);
  localparam logic [32:0] SIZE33 = 33'(BAR_BYTES);

  logic [32:0] end_pos;
  logic        len_ok, align_ok, range_ok;

  always_comb begin
    end_pos  = {1'b0, offs} + {25'd0, len};
    len_ok   = (len == 8'd1) || (len == 8'd2) || (len == 8'd4);
    case (len)
      8'd2:    align_ok = (offs[0] == 1'b0);
      8'd4:    align_ok = (offs[1:0] == 2'b00);
      default: align_ok = 1'b1;
    endcase
    range_ok = ({1'b0, offs} < SIZE33) && (end_pos <= SIZE33);
    acc_ok   = (bar_sel == 8'd0) && len_ok && align_ok && range_ok;
    acc_mask = len_to_bits(len);
  end
endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
#(
  parameter int unsigned BAR_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_ready,
  output logic              cfg_ack,
  output logic              cfg_err,
  output logic [31:0]       cfg_rdata,
  input  logic [7:0]        bar_sel,
  input  logic [7:0]        len,
  input  logic [31:0]       offs,
  input  logic [31:0]       window,
  input  logic              acc_ok,
  input  logic [31:0]       acc_mask,
  output logic              fld_we,
  output logic              win_ld,
  output logic [31:0]       win_d,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BAR_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [31:0]       bus_mask,
  input  logic              bus_resp,
  input  logic [31:0]       bus_rdata
);
  seq_st_t     st;
  logic        accept, is_win, resp_rd;
  logic [31:0] be_bits, merged, rd_masked, word_rd;
  logic [3:0]  be_q;

  always_comb begin
    accept    = cfg_req && (st == ST_IDLE);
    is_win    = (cfg_addr == A_WIN);
    be_bits   = lanes_to_bits(cfg_be);
    merged    = (window & ~be_bits) | (cfg_wdata & be_bits);
    rd_masked = bus_rdata & bus_mask;
    resp_rd   = (st == ST_WAIT) && bus_resp && !bus_we;
    fld_we    = accept && cfg_we && !is_win;
    win_ld    = (accept && cfg_we && is_win && acc_ok) || resp_rd;
    win_d     = resp_rd ? rd_masked : merged;
    cfg_ready = (st == ST_IDLE);
    case (cfg_addr)
      A_CTRL:  word_rd = {16'd0, len, bar_sel};
      A_OFFS:  word_rd = offs;
      A_WIN:   word_rd = window;
      default: word_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cfg_ack   <= 1'b0;
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_mask  <= '0;
      be_q      <= '0;
    end else begin
      cfg_ack <= 1'b0;
      cfg_err <= 1'b0;
      bus_req <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          be_q <= cfg_be;
          if (is_win && acc_ok) begin
            bus_req   <= 1'b1;
            bus_we    <= cfg_we;
            bus_addr  <= offs[BAR_AW-1:0];
            bus_wdata <= merged;
            bus_mask  <= acc_mask;
            st        <= ST_WAIT;
          end else begin
            cfg_ack   <= 1'b1;
            cfg_err   <= is_win;
            cfg_rdata <= word_rd & be_bits;
          end
        end
        ST_WAIT: if (bus_resp) begin
          cfg_ack <= 1'b1;
          st      <= ST_IDLE;
          if (!bus_we) cfg_rdata <= rd_masked & lanes_to_bits(be_q);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge #(
  parameter int unsigned BAR_BYTES = 256,
  localparam int unsigned BAR_AW   = $clog2(BAR_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_ready,
  output logic              cfg_ack,
  output logic              cfg_err,
  output logic [31:0]       cfg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BAR_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [31:0]       bus_mask,
  input  logic              bus_resp,
  input  logic [31:0]       bus_rdata
);
  logic [7:0]  bar_sel, len;
  logic [31:0] offs, window, acc_mask, win_d;
  logic        acc_ok, fld_we, win_ld;

  cfgwin_fields #(.DW(32)) fields_i (
    .clk(clk), .rst(rst), .fld_we(fld_we), .fld_addr(cfg_addr), .fld_be(cfg_be),
    .fld_wdata(cfg_wdata), .win_ld(win_ld), .win_d(win_d), .bar_sel(bar_sel),
    .len(len), .offs(offs), .window(window)
  );

  cfgwin_validate #(.BAR_BYTES(BAR_BYTES)) validate_i (
    .bar_sel(bar_sel), .len(len), .offs(offs), .acc_ok(acc_ok), .acc_mask(acc_mask)
  );

  cfgwin_seq #(.BAR_AW(BAR_AW)) seq_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_ack(cfg_ack),
    .cfg_err(cfg_err), .cfg_rdata(cfg_rdata), .bar_sel(bar_sel), .len(len),
    .offs(offs), .window(window), .acc_ok(acc_ok), .acc_mask(acc_mask),
    .fld_we(fld_we), .win_ld(win_ld), .win_d(win_d), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mask(bus_mask),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/cfgwin_bridge_chk.sv
module cfgwin_bridge_chk #(
  parameter int unsigned BAR_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic              cfg_ready,
  input logic              cfg_ack,
  input logic              cfg_err,
  input logic              bus_req,
  input logic [BAR_AW-1:0] bus_addr,
  input logic [31:0]       bus_mask,
  input logic              bus_resp
);
  logic pend;
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (bus_req) pend <= 1'b1;
    else if (bus_resp) pend <= 1'b0;
  end

  a_r8_req_single: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> !bus_req);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !cfg_ready);
  a_r8_resp_then_ack: assert property (@(posedge clk) disable iff (rst)
    (pend && bus_resp) |=> cfg_ack);
  a_r8_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> cfg_ack);
  a_r6_err_no_bus: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!bus_req && !pend));
  a_r1_field_no_bus: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ready && cfg_addr != 2'd2) |=> !bus_req);
  a_r3_mask_legal: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_mask == 32'h0000_00FF || bus_mask == 32'h0000_FFFF ||
                 bus_mask == 32'hFFFF_FFFF));
  a_r5_half_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_mask == 32'h0000_FFFF) |-> (bus_addr[0] == 1'b0));
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_mask == 32'hFFFF_FFFF) |-> (bus_addr[1:0] == 2'b00));

  logic unused_we;
  assign unused_we = cfg_we;
endmodule

bind cfgwin_bridge cfgwin_bridge_chk #(.BAR_AW(BAR_AW)) chk_i (
  .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_ready(cfg_ready), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .bus_req(bus_req),
  .bus_addr(bus_addr), .bus_mask(bus_mask), .bus_resp(bus_resp)
);

// File: tb/cfgwin_bridge_tb_top.sv
`timescale 1ns/1ps
module cfgwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_ready, cfg_ack, cfg_err;
  logic [31:0] cfg_rdata;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_mask;
  logic        bus_resp = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  cfgwin_bridge #(.BAR_BYTES(256)) dut_i (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_ack(cfg_ack),
    .cfg_err(cfg_err), .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mask(bus_mask),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata)
  );

  int tests = 0, fails = 0, bus_cnt = 0;
  logic [7:0]  mem [0:255];
  logic        last_we;
  logic [7:0]  last_addr;
  logic [31:0] last_mask, last_wdata;
  logic        ready_snap;

  // register-bus model: two-cycle latency, byte-addressed memory
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst && bus_req) begin
        bus_cnt++;
        last_we = bus_we; last_addr = bus_addr;
        last_mask = bus_mask; last_wdata = bus_wdata;
        if (bus_we)
          for (int i = 0; i < 4; i++)
            if (bus_mask[8*i]) mem[(int'(bus_addr) + i) % 256] = bus_wdata[8*i +: 8];
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) bus_rdata[8*i +: 8] = mem[(int'(last_addr) + i) % 256];
        bus_resp = 1'b1;
        @(negedge clk);
        bus_resp = 1'b0;
        bus_rdata = 32'hA5A5_A5A5;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input logic we, input logic [1:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic e, output logic [31:0] rd);
    int n;
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 1'b0;
    ready_snap = cfg_ready;
    n = 0;
    while (!cfg_ack && n < 50) begin @(negedge clk); n++; end
    if (!cfg_ack) chk("R8", "ack timeout", 32'd0, 32'd1);
    e = cfg_err; rd = cfg_rdata;
  endtask

  // we | addr | be | wdata | err | bus | rdata
  localparam int NV = 37;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b0,2'd0,4'hF,32'h0,       1'b0,1'b0,32'h0},
    {1'b1,2'd2,4'hF,32'h12345678,1'b1,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b1,1'b0,32'h0},
    {1'b1,2'd0,4'h3,32'h400,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h10,      1'b0,1'b0,32'h0},
    {1'b1,2'd2,4'hF,32'h11223344,1'b0,1'b1,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b0,1'b1,32'h11223344},
    {1'b1,2'd0,4'h3,32'h100,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h13,      1'b0,1'b0,32'h0},
    {1'b1,2'd2,4'h1,32'hAB,      1'b0,1'b1,32'h0},
    {1'b1,2'd0,4'h3,32'h400,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h10,      1'b0,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b0,1'b1,32'hAB223344},
    {1'b1,2'd0,4'h3,32'h200,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h12,      1'b0,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b0,1'b1,32'h0000AB22},
    {1'b0,2'd2,4'h1,32'h0,       1'b0,1'b1,32'h00000022},
    {1'b1,2'd1,4'hF,32'h11,      1'b0,1'b0,32'h0},
    {1'b1,2'd2,4'hF,32'hFFFFFFFF,1'b1,1'b0,32'h0},
    {1'b0,2'd2,4'h3,32'h0,       1'b1,1'b0,32'h0000AB22},
    {1'b0,2'd0,4'hF,32'h0,       1'b0,1'b0,32'h00000200},
    {1'b1,2'd0,4'h3,32'h401,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h0,       1'b0,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b1,1'b0,32'h0000AB22},
    {1'b1,2'd0,4'h3,32'h400,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'hFC,      1'b0,1'b0,32'h0},
    {1'b1,2'd2,4'hF,32'hCAFEF00D,1'b0,1'b1,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b0,1'b1,32'hCAFEF00D},
    {1'b1,2'd1,4'hF,32'h100,     1'b0,1'b0,32'h0},
    {1'b1,2'd0,4'h3,32'h100,     1'b0,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b1,1'b0,32'hCAFEF00D},
    {1'b1,2'd0,4'h3,32'h300,     1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'hF,32'h0,       1'b0,1'b0,32'h0},
    {1'b0,2'd2,4'hF,32'h0,       1'b1,1'b0,32'hCAFEF00D},
    {1'b0,2'd1,4'hF,32'h0,       1'b0,1'b0,32'h0},
    {1'b1,2'd1,4'h2,32'h3400,    1'b0,1'b0,32'h0},
    {1'b0,2'd1,4'hF,32'h0,       1'b0,1'b0,32'h00003400}
  };

  logic finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic        e;
    logic [31:0] rd;
    int          b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9", "cfg_ready", 32'(cfg_ready), 32'd1);
    chk("R9", "cfg_ack",   32'(cfg_ack),   32'd0);
    chk("R9", "cfg_err",   32'(cfg_err),   32'd0);
    chk("R9", "bus_req",   32'(bus_req),   32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v  = VEC[i];
      b0 = bus_cnt;
      run_cfg(v[72], v[71:70], v[69:66], v[65:34], e, rd);
      chk("R5", $sformatf("vec %0d err", i), 32'(e), 32'(v[33]));
      chk(v[71:70] != 2'd2 ? "R1" : (v[32] ? "R2" : "R6"),
          $sformatf("vec %0d bus count", i), 32'(bus_cnt - b0), 32'(v[32]));
      if (!v[72])
        chk(v[71:70] != 2'd2 ? "R1" : (v[33] ? "R7" : "R4"),
            $sformatf("vec %0d rdata", i), rd, v[31:0]);
    end

    // R4/R3: upper bytes zeroed on a one-byte read, mask from length
    run_cfg(1'b1, 2'd0, 4'h3, 32'h400, e, rd);
    run_cfg(1'b1, 2'd1, 4'hF, 32'h20, e, rd);
    run_cfg(1'b1, 2'd2, 4'hF, 32'hDEADBEEF, e, rd);
    run_cfg(1'b1, 2'd0, 4'h3, 32'h100, e, rd);
    run_cfg(1'b1, 2'd1, 4'hF, 32'h21, e, rd);
    run_cfg(1'b0, 2'd2, 4'hF, 32'h0, e, rd);
    chk("R4", "byte read zero-extended", rd, 32'h0000_00BE);
    chk("R3", "len1 mask", last_mask, 32'h0000_00FF);
    chk("R4", "read addr", 32'(last_addr), 32'h21);

    // R3/R2: halfword length with full-word host write
    run_cfg(1'b1, 2'd0, 4'h3, 32'h200, e, rd);
    run_cfg(1'b1, 2'd1, 4'hF, 32'h40, e, rd);
    run_cfg(1'b1, 2'd2, 4'hF, 32'h55667788, e, rd);
    chk("R3", "len2 mask", last_mask, 32'h0000_FFFF);
    chk("R2", "write addr", 32'(last_addr), 32'h40);
    chk("R2", "write data", last_wdata, 32'h55667788);
    chk("R2", "write strobe", 32'(last_we), 32'd1);
    run_cfg(1'b1, 2'd0, 4'h3, 32'h400, e, rd);
    run_cfg(1'b0, 2'd2, 4'hF, 32'h0, e, rd);
    chk("R3", "only length bytes written", rd, 32'h0000_7788);
    chk("R8", "ready low during bus access", 32'(ready_snap), 32'd0);

    // R8: field access completes without leaving idle
    run_cfg(1'b0, 2'd1, 4'hF, 32'h0, e, rd);
    chk("R8", "ready after field access", 32'(ready_snap), 32'd1);
    chk("R1", "offset readback", rd, 32'h40);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule